// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Controller

This block is the control unit and register set of a small single-accumulator computer. It owns an internal word memory, a program counter, an instruction register, a memory address register and a memory data register. A state machine runs a fetch phase that is the same for every instruction, followed by an execute phase chosen by the opcode. Each access to memory passes through the address and data registers in a fixed order of steps. The address field of an instruction is always used as the effective address, so no address arithmetic is needed.

The instruction set covers add and subtract against the accumulator, loads and stores with a selectable register, an unconditional jump, four jumps that each test one flag, and word transfers between the accumulator and a bank of input and output ports. A halt opcode parks the sequencer. While reset is held low, the program image is written into the memory through a loader port. The program runs once reset is released.

Top module: `accum_cpu_ctrl`

## Requirements
- R1: While reset is low and after it is released, pc_o, acc_o, flags_o, out_ports and out_wr are all zero, halted is low, and the sequencer begins in its first fetch step.
- R2: Fetch takes five cycles: the address register takes the PC, a memory read is issued with one wait cycle, the word is captured in the data register, moved to the instruction register, and the PC is incremented while the opcode is decoded. In particular, the program of the bench (IN, ADD, OUT) shows its first out_wr after exactly 22 clocks.
- R3: An instruction word is laid out as opcode in bits [11:8], register select in bits [7:6] and address in bits [5:0].
- R4: ADD (opcode 0) and SUB (opcode 1) read the addressed word into auxiliary register 1 and then write ACC+word or ACC-word into ACC. Both update all four flags. SUB sets the carry flag when a borrow occurs (ACC < word, unsigned).
- R5: The flags use these bits: zero (ACC is zero) in bit 0, sign (ACC msb) in bit 1, parity (an odd number of ones in ACC) in bit 2, and carry in bit 3.
- R6: LOAD (opcode 2) with register select 0 writes the word into ACC and updates zero, sign and parity, leaving carry unchanged. Register select 1 to 3 writes auxiliary register 1 to 3 instead and leaves the flags unchanged.
- R7: STORE (opcode 3) moves ACC (register select 0) or auxiliary register 1 to 3 into the data register, then writes it to the addressed word.
- R8: JMP (opcode 4) loads the PC from the address field and starts the next fetch.
- R9: JZ, JS, JP and JC (opcodes 5 to 8) test flag bit (opcode-5). When the flag is set, the PC is loaded from the address field. When it is clear, the PC keeps its incremented value.
- R10: IN (opcode 9) copies input port address[1:0] into ACC and updates zero, sign and parity.
- R11: OUT (opcode 10) writes ACC into output port address[1:0]. In the next cycle out_wr is high for exactly one cycle and out_sel names that port.
- R12: HALT (opcode 15) raises halted and freezes the PC and the sequencer. Opcodes 11 to 14 do nothing and the next fetch follows.
- R13: Loader writes take effect only while reset is low. ld_en held high during a run leaves the program untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Loader write enable, honoured only in reset |
| ld_addr | input | AW | Loader word address |
| ld_data | input | DW | Loader word |
| in_ports | input | NPORT*DW | Input port words, port p at [p*DW +: DW] |
| out_ports | output | NPORT*DW | Output port registers, port p at [p*DW +: DW] |
| out_wr | output | 1 | One-cycle pulse after an output port write |
| out_sel | output | PSW | Port written in the pulse cycle |
| pc_o | output | AW | Program counter |
| acc_o | output | DW | Accumulator |
| flags_o | output | 4 | Flags {carry, parity, sign, zero} |
| halted | output | 1 | Sequencer parked on HALT |

## Verification
The assertions assume that the memory image the loader writes during reset is the program the sequencer executes. They also assume that input ports are sampled only in the IN execute cycle, so the ports may change at any time. The bench loads every word of memory before it releases reset and sets the input ports before release. It runs a program that reaches HALT, so the halt assertions always see a stable end state. The loader is left enabled during the run to exercise the reset-only gating without disturbing any property.

// File: rtl/accum_pkg.sv
package accum_pkg;

   localparam int OPW = 4;
   localparam int NFLAG = 4;

   localparam int FZ = 0;
   localparam int FS = 1;
   localparam int FP = 2;
   localparam int FC = 3;

   typedef enum logic [OPW-1:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_LOAD  = 4'd2,
      OP_STORE = 4'd3,
      OP_JMP   = 4'd4,
      OP_JZ    = 4'd5,
      OP_JS    = 4'd6,
      OP_JP    = 4'd7,
      OP_JC    = 4'd8,
      OP_IN    = 4'd9,
      OP_OUT   = 4'd10,
      OP_HALT  = 4'd15
   } opcode_e;

   typedef enum logic [3:0] {
      S_FA, S_FR, S_FC, S_FI, S_FD,
      S_EA, S_ER, S_EC, S_XR, S_XA,
      S_SW1, S_SW2, S_IO, S_HALT
   } state_e;

endpackage

// File: rtl/accum_mem.sv
module accum_mem #(
   parameter int AW = 6,
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          ld_act,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (ld_act)
         mem_q[ld_addr] <= ld_data;
      else if (wr_en)
         mem_q[addr] <= wdata;
      if (rd_en)
         rdata <= mem_q[addr];
   end
endmodule

// File: rtl/accum_flagcalc.sv
module accum_flagcalc #(
   parameter int DW = 12
) (
   input  logic [DW-1:0] val,
   output logic          z_o,
   output logic          s_o,
   output logic          p_o
);
   assign z_o = (val == '0);
   assign s_o = val[DW-1];
   assign p_o = ^val;
endmodule

// File: rtl/accum_alu.sv
module accum_alu #(
   parameter int DW = 12
) (
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic          sub,
   output logic [DW-1:0] res,
   output logic [3:0]    flags_o
);
   logic [DW:0] ext;
   logic        z, s, p;

   always_comb begin
      if (sub)
         ext = {1'b0, op_a} - {1'b0, op_b};
      else
         ext = {1'b0, op_a} + {1'b0, op_b};
   end

   assign res = ext[DW-1:0];

   accum_flagcalc #(.DW(DW)) u_fl (.val(res), .z_o(z), .s_o(s), .p_o(p));

   assign flags_o = {ext[DW], p, s, z};
endmodule

// File: rtl/accum_outbank.sv
module accum_outbank #(
   parameter int DW = 12,
   parameter int NPORT = 4,
   parameter int PSW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PSW-1:0]    sel,
   input  logic [DW-1:0]     wdata,
   output logic [NPORT*DW-1:0] regs_o
);
   for (genvar g = 0; g < NPORT; g++) begin : g_port
      logic [DW-1:0] reg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q <= '0;
         else if (we && (sel == PSW'(g)))
            reg_q <= wdata;
      end
      assign regs_o[g*DW +: DW] = reg_q;
   end
endmodule

// File: rtl/accum_cpu_ctrl.sv
module accum_cpu_ctrl
   import accum_pkg::*;
#(
   parameter int AW = 6,
   parameter int RSW = 2,
   parameter int NPORT = 4,
   localparam int DW = OPW + RSW + AW,
   localparam int PSW = $clog2(NPORT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_en,
   input  logic [AW-1:0]       ld_addr,
   input  logic [DW-1:0]       ld_data,
   input  logic [NPORT*DW-1:0] in_ports,
   output logic [NPORT*DW-1:0] out_ports,
   output logic                out_wr,
   output logic [PSW-1:0]      out_sel,
   output logic [AW-1:0]       pc_o,
   output logic [DW-1:0]       acc_o,
   output logic [NFLAG-1:0]    flags_o,
   output logic                halted
);
   initial begin
      assert (NPORT >= 2 && (1 << PSW) == NPORT && NPORT <= (1 << AW))
         else $fatal(1, "NPORT must be a power of two between 2 and 2**AW");
      assert (RSW == 2) else $fatal(1, "register select must be 2 bits");
      assert (AW >= 2) else $fatal(1, "AW too small");
   end

   state_e            state_q;
   logic [AW-1:0]     pc_q, mar_q;
   logic [DW-1:0]     mbr_q, ir_q, acc_q;
   logic [DW-1:0]     rx1_q, rx2_q, rx3_q;
   logic [NFLAG-1:0]  flags_q;
   logic              out_wr_q;
   logic [PSW-1:0]    out_sel_q;

   opcode_e           op;
   logic [OPW-1:0]    op_raw;
   logic [RSW-1:0]    rsel;
   logic [AW-1:0]     ir_adr;
   logic [PSW-1:0]    port_sel;
   logic [1:0]        cond_idx;

   assign op_raw   = ir_q[DW-1 -: OPW];
   assign op       = opcode_e'(op_raw);
   assign rsel     = ir_q[AW +: RSW];
   assign ir_adr   = ir_q[AW-1:0];
   assign port_sel = ir_adr[PSW-1:0];
   assign cond_idx = 2'(op_raw - OPW'(OP_JZ));

   // memory
   logic          mem_rd, mem_wr;
   logic [DW-1:0] mem_rdata;

   assign mem_rd = (state_q == S_FR) || (state_q == S_ER);
   assign mem_wr = (state_q == S_SW2);

   accum_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk     (clk),
      .ld_act  (ld_en && !rst_n),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .rd_en   (mem_rd),
      .wr_en   (mem_wr),
      .addr    (mar_q),
      .wdata   (mbr_q),
      .rdata   (mem_rdata)
   );

   // arithmetic
   logic [DW-1:0]    alu_res;
   logic [NFLAG-1:0] alu_flags;

   accum_alu #(.DW(DW)) u_alu (
      .op_a    (acc_q),
      .op_b    (rx1_q),
      .sub     (op == OP_SUB),
      .res     (alu_res),
      .flags_o (alu_flags)
   );

   // flags for loads and inputs
   logic [DW-1:0] in_word, mv_word;
   logic          mv_z, mv_s, mv_p;

   assign in_word = in_ports[port_sel*DW +: DW];
   assign mv_word = (state_q == S_IO) ? in_word : mbr_q;

   accum_flagcalc #(.DW(DW)) u_mvfl (.val(mv_word), .z_o(mv_z), .s_o(mv_s), .p_o(mv_p));

   // store source
   logic [DW-1:0] st_src;
   always_comb begin
      case (rsel)
         2'd1:    st_src = rx1_q;
         2'd2:    st_src = rx2_q;
         2'd3:    st_src = rx3_q;
         default: st_src = acc_q;
      endcase
   end

   // output ports
   accum_outbank #(.DW(DW), .NPORT(NPORT), .PSW(PSW)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     ((state_q == S_IO) && (op == OP_OUT)),
      .sel    (port_sel),
      .wdata  (acc_q),
      .regs_o (out_ports)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_FA;
         pc_q      <= '0;
         mar_q     <= '0;
         mbr_q     <= '0;
         ir_q      <= '0;
         acc_q     <= '0;
         rx1_q     <= '0;
         rx2_q     <= '0;
         rx3_q     <= '0;
         flags_q   <= '0;
         out_wr_q  <= 1'b0;
         out_sel_q <= '0;
      end else begin
         out_wr_q <= 1'b0;
         case (state_q)
            S_FA: begin
               mar_q   <= pc_q;
               state_q <= S_FR;
            end
            S_FR: state_q <= S_FC;
            S_FC: begin
               mbr_q   <= mem_rdata;
               state_q <= S_FI;
            end
            S_FI: begin
               ir_q    <= mbr_q;
               state_q <= S_FD;
            end
            S_FD: begin
               pc_q <= pc_q + AW'(1);
               case (op)
                  OP_ADD, OP_SUB, OP_LOAD, OP_STORE: state_q <= S_EA;
                  OP_JMP: begin
                     pc_q    <= ir_adr;
                     state_q <= S_FA;
                  end
                  OP_JZ, OP_JS, OP_JP, OP_JC: begin
                     if (flags_q[cond_idx])
                        pc_q <= ir_adr;
                     state_q <= S_FA;
                  end
                  OP_IN, OP_OUT: state_q <= S_IO;
                  OP_HALT: state_q <= S_HALT;
                  default: state_q <= S_FA;
               endcase
            end
            S_EA: begin
               mar_q   <= ir_adr;
               state_q <= (op == OP_STORE) ? S_SW1 : S_ER;
            end
            S_ER: state_q <= S_EC;
            S_EC: begin
               mbr_q   <= mem_rdata;
               state_q <= S_XR;
            end
            S_XR: begin
               if (op == OP_LOAD) begin
                  case (rsel)
                     2'd1: rx1_q <= mbr_q;
                     2'd2: rx2_q <= mbr_q;
                     2'd3: rx3_q <= mbr_q;
                     default: begin
                        acc_q       <= mbr_q;
                        flags_q[FZ] <= mv_z;
                        flags_q[FS] <= mv_s;
                        flags_q[FP] <= mv_p;
                     end
                  endcase
                  state_q <= S_FA;
               end else begin
                  rx1_q   <= mbr_q;
                  state_q <= S_XA;
               end
            end
            S_XA: begin
               acc_q   <= alu_res;
               flags_q <= alu_flags;
               state_q <= S_FA;
            end
            S_SW1: begin
               mbr_q   <= st_src;
               state_q <= S_SW2;
            end
            S_SW2: state_q <= S_FA;
            S_IO: begin
               if (op == OP_IN) begin
                  acc_q       <= in_word;
                  flags_q[FZ] <= mv_z;
                  flags_q[FS] <= mv_s;
                  flags_q[FP] <= mv_p;
               end else begin
                  out_wr_q  <= 1'b1;
                  out_sel_q <= port_sel;
               end
               state_q <= S_FA;
            end
            S_HALT: state_q <= S_HALT;
            default: state_q <= S_FA;
         endcase
      end
   end

   assign out_wr  = out_wr_q;
   assign out_sel = out_sel_q;
   assign pc_o    = pc_q;
   assign acc_o   = acc_q;
   assign flags_o = flags_q;
   assign halted  = (state_q == S_HALT);
endmodule

// File: rtl/accum_cpu_ctrl_chk.sv
module accum_cpu_ctrl_chk
   import accum_pkg::*;
#(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input state_e        state,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] mar,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic          out_wr,
   input logic          halted
);
   // R2
   fetch_mar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FA) |=> (mar == $past(pc)));

   // R2
   read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (state == S_FC || state == S_EC));

   // R7
   write_after_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(state) == S_SW1));

   // R7
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

   // R11
   out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |=> !out_wr);

   // R12
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc)));
endmodule

bind accum_cpu_ctrl accum_cpu_ctrl_chk #(.AW(AW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .state  (state_q),
   .pc     (pc_q),
   .mar    (mar_q),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .out_wr (out_wr),
   .halted (halted)
);

// File: tb/tb_accum_cpu_ctrl.sv
module tb_accum_cpu_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int NPORT = 4;
   localparam int DW = 12;
   localparam int PSW = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                ld_en = 1'b0;
   logic [AW-1:0]       ld_addr = '0;
   logic [DW-1:0]       ld_data = '0;
   logic [NPORT*DW-1:0] in_ports = '0;
   logic [NPORT*DW-1:0] out_ports;
   logic                out_wr;
   logic [PSW-1:0]      out_sel;
   logic [AW-1:0]       pc_o;
   logic [DW-1:0]       acc_o;
   logic [3:0]          flags_o;
   logic                halted;

   accum_cpu_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .in_ports(in_ports), .out_ports(out_ports), .out_wr(out_wr), .out_sel(out_sel),
      .pc_o(pc_o), .acc_o(acc_o), .flags_o(flags_o), .halted(halted)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit first_out_seen = 0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   typedef struct {
      logic [PSW-1:0] sel;
      logic [DW-1:0]  val;
      string          tag;
   } exp_t;
   exp_t exp_q[$];

   task automatic push_exp(int sel, logic [DW-1:0] val, string tag);
      exp_t e;
      e.sel = PSW'(sel);
      e.val = val;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   function automatic logic [DW-1:0] ins(int op, int rs, int a);
      return DW'((op << 8) | (rs << 6) | a);
   endfunction

   // monitor: pops expected port writes
   always @(negedge clk) begin
      if (rst_n && out_wr) begin
         if (!first_out_seen) begin
            first_out_seen = 1;
            chk("R2 first out_wr cycle", cyc, 22);
         end
         if (exp_q.size() == 0) begin
            chk("R11 unexpected port write", {out_sel, out_ports[out_sel*DW +: DW]}, 32'hFFFF);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, {20'(out_sel), out_ports[out_sel*DW +: DW]}, {20'(e.sel), e.val});
         end
      end
   end

   logic [DW-1:0] img [64];

   initial begin
      for (int i = 0; i < 64; i++) img[i] = '0;
      img[0]  = ins(9, 0, 1);    // IN 1
      img[1]  = ins(0, 0, 40);   // ADD
      img[2]  = ins(10, 0, 0);   // OUT 0
      img[3]  = ins(1, 0, 41);   // SUB
      img[4]  = ins(10, 0, 1);   // OUT 1
      img[5]  = ins(1, 0, 40);   // SUB with borrow
      img[6]  = ins(8, 0, 9);    // JC taken
      img[7]  = ins(10, 0, 3);
      img[8]  = ins(15, 0, 0);
      img[9]  = ins(5, 0, 7);    // JZ not taken
      img[10] = ins(10, 0, 2);   // OUT 2
      img[11] = ins(3, 0, 50);   // STORE ACC
      img[12] = ins(2, 1, 40);   // LOAD RX1
      img[13] = ins(2, 0, 50);   // LOAD ACC
      img[14] = ins(0, 0, 42);   // ADD to zero with carry
      img[15] = ins(5, 0, 17);   // JZ taken
      img[16] = ins(15, 0, 0);
      img[17] = ins(10, 0, 3);   // OUT 3
      img[18] = ins(2, 2, 43);   // LOAD RX2
      img[19] = ins(3, 2, 51);   // STORE RX2
      img[20] = ins(2, 0, 51);   // LOAD ACC
      img[21] = ins(7, 0, 23);   // JP taken
      img[22] = ins(15, 0, 0);
      img[23] = ins(12, 0, 5);   // unused opcode
      img[24] = ins(10, 0, 0);   // OUT 0
      img[25] = ins(6, 0, 27);   // JS not taken
      img[26] = ins(4, 0, 28);   // JMP
      img[27] = ins(15, 0, 0);
      img[28] = ins(9, 0, 2);    // IN 2
      img[29] = ins(10, 0, 1);   // OUT 1
      img[30] = ins(15, 0, 0);   // HALT
      img[40] = 12'h123;
      img[41] = 12'h0FF;
      img[42] = 12'h0FA;
      img[43] = 12'h554;

      in_ports[0*DW +: DW] = 12'h777;
      in_ports[1*DW +: DW] = 12'h005;
      in_ports[2*DW +: DW] = 12'h9AB;
      in_ports[3*DW +: DW] = 12'h000;

      push_exp(0, 12'h128, "R4 R10 ADD after IN on port 0");
      push_exp(1, 12'h029, "R4 SUB no borrow on port 1");
      push_exp(2, 12'hF06, "R9 JC taken, JZ not taken, port 2");
      push_exp(3, 12'h000, "R7 R6 store/reload, ADD wrap, JZ taken, port 3");
      push_exp(0, 12'h554, "R7 RX2 store, R9 JP taken, R12 no-op, port 0");
      push_exp(1, 12'h9AB, "R8 JMP, R9 JS not taken, R10 IN port 1");

      // load memory in reset
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         ld_en   = 1'b1;
         ld_addr = AW'(i);
         ld_data = img[i];
      end
      @(negedge clk);
      chk("R1 pc in reset", pc_o, 0);
      chk("R1 acc in reset", acc_o, 0);
      chk("R1 flags in reset", flags_o, 0);
      chk("R1 halted in reset", halted, 0);
      chk("R1 out_wr in reset", out_wr, 0);
      chk("R1 out ports in reset", (out_ports == '0), 1);

      // release reset; loader held active with a HALT aimed at word 10 (R13)
      ld_addr = AW'(10);
      ld_data = ins(15, 0, 0);
      ld_en   = 1'b1;
      rst_n   = 1'b1;

      begin
         bit done = 0;
         for (int i = 0; i < 3000 && !done; i++) begin
            @(negedge clk);
            if (halted) done = 1;
         end
         if (!done) chk("watchdog: HALT not reached", 0, 1);
      end
      ld_en = 1'b0;

      chk("R12 pc after HALT", pc_o, 31);
      repeat (5) @(negedge clk);
      chk("R12 pc frozen", pc_o, 31);
      chk("R12 still halted", halted, 1);
      chk("R10 acc after IN", acc_o, 12'h9AB);
      chk("R5 R6 final flags {C,P,S,Z}", flags_o, 4'b1110);
      chk("R11 all port writes seen", exp_q.size(), 0);
      chk("R13 loader ignored, port 2 written", out_ports[2*DW +: DW], 12'hF06);
      chk("R11 port 0 final", out_ports[0*DW +: DW], 12'h554);
      chk("R11 port 1 final", out_ports[1*DW +: DW], 12'h9AB);
      chk("R11 port 3 final", out_ports[3*DW +: DW], 12'h000);
      chk("R3 R2 an out_wr was observed", first_out_seen, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule